// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write the management registers of up to 32 Ethernet PHYs over the two-wire MDC/MDIO management bus. The host loads a PHY address, a register address and an operation bit into an address register. For writes, it also loads the 16-bit value into a write-data register. It then starts the transfer through a control register. The block divides the system clock down to MDC and shifts out a complete management frame on MDIO. On a read, it releases the line so that the PHY can answer, and it captures the 16 returned bits into a read-data register.

Completion is reported through a busy bit in the control register. The host sets this bit to launch a transfer, the hardware holds it at 1 while the frame is on the wire, and the hardware clears it when the frame ends. MDIO appears as a separate output, output enable and input, so that a pad tristate buffer can be placed outside the block.

Top module: `mdio_mgmt_master`

## Requirements
- R1: MDC is low while idle. During a frame it toggles every HALF_DIV system clocks, so the full period is 2*HALF_DIV clocks (80 clocks = 400 ns at 200 MHz by default).
- R2: A transfer starts only on a write to the control register (offset 0x7F0) while idle, with bit 0 = 1 and bit 3 (enable) = 1. A write with bit 0 = 1 and bit 3 = 0 starts nothing.
- R3: Control bit 0 reads 1 from the cycle after the start write until the frame ends, and then reads 0.
- R4: A frame is 64 bit times, in this order: 32 ones, start code 0 then 1, a 2-bit opcode, the 5-bit PHY address, the 5-bit register address, 2 turnaround bits, and 16 data bits. All fields are sent MSB first.
- R5: Address register bit 10 selects the operation, with 0 meaning write and 1 meaning read. The opcode is sent as 0,1 for a write and 1,0 for a read. The PHY address is taken from bits 9:5 and the register address from bits 4:0.
- R6: On a write, the master drives all 64 bit times. The turnaround is sent as 1 then 0, followed by write-data register bits 15:0.
- R7: On a read, the output enable is low for the two turnaround bits and the 16 data bits. MDIO is sampled at each rising MDC edge of the data bits, and at completion the 16 bits appear in the read-data register (offset 0x7EC, bits 15:0). A write transfer leaves the read-data register unchanged.
- R8: MDIO output changes occur only at falling MDC edges. When the frame ends, MDC is low and the output enable is low.
- R9: Writes to the address, write-data and control registers are ignored while busy, so the frame on the wire and the register readback stay unchanged.
- R10: The address register (0x7E4, bits 10:0) and the write-data register (0x7E8, bits 15:0) read back what was written. The control register reads the enable bit at bit 3 and busy at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
Random reads and writes are run with random PHY addresses, register addresses, write data and returned PHY data. Matching the captured wire bits against the expected frame separates the read opcode from the write opcode and also catches wrong field placement or bit order. The bench also checks the output-enable pattern for each operation, which shows whether the line is released exactly over the turnaround and data bits on a read. Directed cases cover a start request with the enable bit clear, register writes issued in the middle of a frame, and data patterns of all ones and all zeros.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int HALF_DIV = 40,
  parameter int AW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam logic [AW-1:0] OFF_ADDR = AW'(12'h7E4);
  localparam logic [AW-1:0] OFF_WDAT = AW'(12'h7E8);
  localparam logic [AW-1:0] OFF_RDAT = AW'(12'h7EC);
  localparam logic [AW-1:0] OFF_CTRL = AW'(12'h7F0);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam int TA_IDX = 46;
  localparam int DATA_IDX = 48;

  logic [10:0]   addr_q;
  logic [15:0]   wdat_q, rdat_q, shin_q;
  logic          en_q, busy_q, mdc_q;
  logic [CW-1:0] cnt_q;
  logic [5:0]    idx_q;

  wire        is_rd   = addr_q[10];
  wire        tick    = busy_q && (cnt_q == CW'(HALF_DIV - 1));
  wire        wr_ctrl = reg_wr && (reg_addr == OFF_CTRL) && !busy_q;
  wire        start   = wr_ctrl && reg_wdata[0] && reg_wdata[3];
  wire [63:0] frame   = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01),
                         addr_q[9:5], addr_q[4:0], (is_rd ? 2'b00 : 2'b10),
                         (is_rd ? 16'h0000 : wdat_q)};

  assign mdc     = mdc_q;
  assign mdio_o  = busy_q ? frame[6'd63 - idx_q] : 1'b1;
  assign mdio_oe = busy_q && (!is_rd || (idx_q < 6'(TA_IDX)));

  always_comb begin
    case (reg_addr)
      OFF_ADDR: reg_rdata = {21'b0, addr_q};
      OFF_WDAT: reg_rdata = {16'b0, wdat_q};
      OFF_RDAT: reg_rdata = {16'b0, rdat_q};
      OFF_CTRL: reg_rdata = {28'b0, en_q, 2'b00, busy_q};
      default:  reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; wdat_q <= '0; rdat_q <= '0; shin_q <= '0;
      en_q <= 1'b0; busy_q <= 1'b0; mdc_q <= 1'b0;
      cnt_q <= '0; idx_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= reg_wdata[3];
      if (reg_wr && reg_addr == OFF_ADDR && !busy_q) addr_q <= reg_wdata[10:0];
      if (reg_wr && reg_addr == OFF_WDAT && !busy_q) wdat_q <= reg_wdata[15:0];
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        idx_q  <= '0;
        mdc_q  <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= tick ? '0 : cnt_q + 1'b1;
        if (tick) begin
          mdc_q <= ~mdc_q;
          if (mdc_q) begin
            if (idx_q == 6'd63) begin
              busy_q <= 1'b0;
              if (is_rd) rdat_q <= shin_q;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else if (is_rd && idx_q >= 6'(DATA_IDX)) begin
            shin_q <= {shin_q[14:0], mdio_i};
          end
        end
      end
    end
  end

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(reg_wr && reg_addr == OFF_CTRL && reg_wdata[0] && reg_wdata[3]));
  // R8
  end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !mdc && !mdio_oe);
  // R8
  launch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $fell(mdc_q));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(addr_q) && $stable(wdat_q) && $stable(en_q)));
  // R7
  rdata_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdat_q) |-> ($fell(busy_q) && is_rd));
  // R1
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc_q) |-> $past(busy_q));
endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/100ps
module test_mdio_mgmt_master;
  localparam int HALF = 40;
  localparam logic [11:0] A_ADDR = 12'h7E4, A_WDAT = 12'h7E8, A_RDAT = 12'h7EC, A_CTRL = 12'h7F0;

  logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] last_rd = 16'h0;

  mdio_mgmt_master #(.HALF_DIV(HALF), .AW(12)) i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
  endfunction

  function automatic logic [63:0] exp_oe(input bit rd);
    return rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic txn(input bit op, input logic [4:0] phy, input logic [4:0] ra,
                     input logic [15:0] wd, input logic [15:0] pd, input bit disturb);
    logic [63:0] cap_d, cap_oe;
    logic [31:0] v;
    int t0 = 0, t1 = 0, n = 0;
    wr(A_ADDR, {21'b0, op, phy, ra});
    wr(A_WDAT, {16'b0, wd});
    wr(A_CTRL, 32'h9);
    rd(A_CTRL, v);
    check(v[0] == 1'b1 && v[3] == 1'b1, "R3 busy after start", v, 64'h9);
    if (disturb) begin
      wr(A_ADDR, {21'b0, ~op, ~phy, ~ra});
      wr(A_WDAT, {16'b0, ~wd});
      wr(A_CTRL, 32'h0);
    end
    for (int k = 0; k < 64; k++) begin
      @(posedge mdc);
      cap_d[63-k] = mdio_o;
      cap_oe[63-k] = mdio_oe;
      if (k == 0) t0 = cyc;
      if (k == 1) t1 = cyc;
      mdio_i = (op && k + 1 >= 48 && k + 1 <= 63) ? pd[15-(k+1-48)] : 1'b1;
    end
    check(t1 - t0 == 2 * HALF, "R1 mdc period", 64'(t1 - t0), 64'(2 * HALF));
    check(cap_d == exp_frame(op, phy, ra, wd), op ? "R4 R5 R7 read frame" : "R4 R5 R6 write frame",
          cap_d, exp_frame(op, phy, ra, wd));
    check(cap_oe == exp_oe(op), op ? "R7 read oe release" : "R6 write oe", cap_oe, exp_oe(op));
    v = 32'h1;
    while (v[0] && n < 400) begin rd(A_CTRL, v); n++; end
    mdio_i = 1'b1;
    check(v[0] == 1'b0, "R3 busy clears", v, 64'h8);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 released after frame", {mdc, mdio_oe}, 64'h0);
    rd(A_RDAT, v);
    if (op) last_rd = pd;
    check(v[15:0] == last_rd, op ? "R7 read data" : "R7 rdata unchanged by write", v, {48'h0, last_rd});
    rd(A_ADDR, v);
    check(v[10:0] == {op, phy, ra}, disturb ? "R9 addr write ignored" : "R10 addr readback", v, {53'h0, op, phy, ra});
    rd(A_WDAT, v);
    check(v[15:0] == wd, disturb ? "R9 wdata write ignored" : "R10 wdata readback", v, {48'h0, wd});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(A_CTRL, v);
    check(v == 32'h0 && mdc == 0 && mdio_oe == 0, "R1 R8 reset idle", {v, mdc, mdio_oe}, 64'h0);

    wr(A_CTRL, 32'h1);
    repeat (3 * HALF) @(negedge clk);
    rd(A_CTRL, v);
    check(v == 32'h0 && mdc == 0 && mdio_oe == 0, "R2 start without enable ignored", v, 64'h0);
    wr(A_CTRL, 32'h8);
    rd(A_CTRL, v);
    check(v == 32'h8, "R10 R2 enable only, not busy", v, 64'h8);

    txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1'b0);
    txn(1'b1, 5'h00, 5'h00, 16'h0, 16'hFFFF, 1'b0);
    txn(1'b1, 5'h15, 5'h0A, 16'h0, 16'h0000, 1'b0);
    txn(1'b0, 5'h0A, 5'h15, 16'hA55A, 16'h0, 1'b1);
    txn(1'b1, 5'h03, 5'h11, 16'h0, 16'h8001, 1'b1);
    for (int i = 0; i < 8; i++)
      txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule